// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block sits beside the command path of a four-bank SDRAM controller and follows every decoded command sent to the device. For each bank it tracks whether a row is open and which row it is. It also checks each command against the device's legality rules. A command that breaks a rule leaves all bank state unchanged and produces a one-cycle illegal pulse with a reason code. A controller or a verification monitor uses these outputs to keep its own scheduling consistent with the state of the part.

The mode register is write-only and holds random contents after power-up. For this reason the block rejects every access until a valid mode register set has been accepted. The block stores the burst length and the write mode from that command. It uses them to time the automatic close that follows a write with auto-precharge, and to reject that command when full-page bursts are configured. Timing parameters, refresh scheduling and the data path are not handled here.

Top module: `sdram_bank_tracker`

## Requirements
- R1: While reset is low, and after it is released, all bank open flags are 0, configured_o is 0 and illegal_o is 0.
- R2: Command codes are: NOP 0, activate 1, read 2, write 3, write with auto-precharge 4, precharge bank 5, precharge all 6, refresh 7, mode register set 8. Codes 9 to 15 act as NOP. Before a mode register set is accepted, any code 1 to 7 is rejected with reason 1 and changes no state.
- R3: A mode register set takes its burst code from cmd_addr[2:0] (0, 1, 2 and 3 give bursts of 1, 2, 4 and 8; 7 gives full page) and single-write mode from cmd_addr[9]. Codes 4 to 6 are rejected with reason 7. An accepted set raises configured_o one cycle later.
- R4: cmd_bank value b selects bank b: both bits low give bank 0, bit 0 alone gives bank 1, bit 1 alone gives bank 2, and both bits give bank 3. Bank b's flag is bank_open_o[b] and its row is bank_row_o[12*b +: 12].
- R5: An activate to an idle bank sets its open flag and latches cmd_addr as the row. An activate to an open bank is rejected with reason 3, and the stored row is kept.
- R6: A read, write or write with auto-precharge to a bank with no open row is rejected with reason 2, and no bank changes.
- R7: A precharge closes only the selected bank; a precharge to an idle bank is legal and changes nothing. A precharge all closes every bank in the same cycle and cancels any pending automatic close.
- R8: A write with auto-precharge issued in cycle t has length L, which is 1 in single-write mode and the burst length otherwise. Its bank's open flag reads 0 from cycle t+L onward.
- R9: A write with auto-precharge is rejected with reason 4 when full page is configured in burst-write mode. In single-write mode with full page it is legal and closes its bank from cycle t+1.
- R10: While a bank waits for its automatic close, an activate, read, write, write with auto-precharge or precharge addressed to it is rejected with reason 6.
- R11: A refresh, or a mode register set after configuration, with any bank open is rejected with reason 5. A refresh with all banks idle is legal and changes nothing.
- R12: illegal_o and illegal_reason_o reflect the command of the previous cycle. The reason is 0 when that command was legal or a NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| cmd_code | input | 4 | Decoded command code |
| cmd_bank | input | 2 | Bank select |
| cmd_addr | input | 12 | Row address, or mode field on a mode register set |
| bank_open_o | output | 4 | Open-row flag per bank |
| bank_row_o | output | 48 | Latched row per bank, 12 bits each |
| configured_o | output | 1 | A mode register set has been accepted |
| illegal_o | output | 1 | Previous command was rejected |
| illegal_reason_o | output | 3 | Reason for the rejection, 0 if none |

## Verification
A command driven in cycle t is captured on the edge that closes that cycle. Its legality verdict, open flags, rows and configured flag all appear in cycle t+1. The one exception is the automatic close after a write with auto-precharge, which appears in cycle t+L. The bench drives on the falling edge and compares on the next falling edge, so every command gets exactly one cycle of latency. A reference model advanced once per edge holds the countdown for each pending close, so those late transitions are checked in the cycle they are due.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_WRA  = 4'd4,
    CMD_PRE  = 4'd5,
    CMD_PALL = 4'd6,
    CMD_REF  = 4'd7,
    CMD_MRS  = 4'd8
  } sbt_cmd_e;

  typedef enum logic [2:0] {
    RSN_NONE        = 3'd0,
    RSN_UNCFG       = 3'd1,
    RSN_IDLE_BANK   = 3'd2,
    RSN_ROW_OPEN    = 3'd3,
    RSN_FULLPAGE_AP = 3'd4,
    RSN_NOT_IDLE    = 3'd5,
    RSN_AP_BUSY     = 3'd6,
    RSN_BAD_MODE    = 3'd7
  } sbt_reason_e;

  localparam logic [2:0] BL_FULL_PAGE = 3'd7;

endpackage

// File: rtl/sbt_mode_reg.sv
module sbt_mode_reg #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [2:0]       bl_in,
  input  logic             single_in,
  output logic             configured,
  output logic             wra_ban,
  output logic [CNT_W-1:0] wr_len
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic       cfg_q, cfg_d;
  logic [2:0] bl_q;
  logic       single_q;

  always_comb begin
    cfg_d = cfg_q;
    if (load) cfg_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= 1'b0;
    else        cfg_q <= cfg_d;
  end

  // mode fields are left unreset: their content is meaningless until loaded
  always_ff @(posedge clk) begin
    if (load) begin
      bl_q     <= bl_in;
      single_q <= single_in;
    end
  end

  assign configured = cfg_q;
  assign wra_ban    = !single_q && (bl_q == sbt_pkg::BL_FULL_PAGE);
  assign wr_len     = single_q ? ONE : (ONE << bl_q[1:0]);

endmodule

// File: rtl/sbt_cmd_check.sv
module sbt_cmd_check
  import sbt_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BANK_W = 2
) (
  input  sbt_cmd_e          cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic              configured,
  input  logic [NB-1:0]     open,
  input  logic [NB-1:0]     busy,
  input  logic              wra_ban,
  input  logic [2:0]        mode_bl,
  output logic              illegal,
  output sbt_reason_e       reason,
  output logic [NB-1:0]     act_sel,
  output logic [NB-1:0]     pre_sel,
  output logic [NB-1:0]     wra_sel,
  output logic              pall,
  output logic              mrs_load
);
  logic [NB-1:0] hit;
  logic          sel_open, sel_busy, any_open;
  sbt_reason_e   rsn;

  always_comb begin
    hit       = '0;
    hit[bank] = 1'b1;
    sel_open  = open[bank];
    sel_busy  = busy[bank];
    any_open  = |open;
    rsn       = RSN_NONE;
    act_sel   = '0;
    pre_sel   = '0;
    wra_sel   = '0;
    pall      = 1'b0;
    mrs_load  = 1'b0;
    if (!configured && (cmd inside {CMD_ACT, CMD_RD, CMD_WR, CMD_WRA,
                                    CMD_PRE, CMD_PALL, CMD_REF})) begin
      rsn = RSN_UNCFG;
    end else begin
      case (cmd)
        CMD_ACT: begin
          if (sel_busy)      rsn = RSN_AP_BUSY;
          else if (sel_open) rsn = RSN_ROW_OPEN;
          else               act_sel = hit;
        end
        CMD_RD, CMD_WR: begin
          if (sel_busy)       rsn = RSN_AP_BUSY;
          else if (!sel_open) rsn = RSN_IDLE_BANK;
        end
        CMD_WRA: begin
          if (wra_ban)        rsn = RSN_FULLPAGE_AP;
          else if (sel_busy)  rsn = RSN_AP_BUSY;
          else if (!sel_open) rsn = RSN_IDLE_BANK;
          else                wra_sel = hit;
        end
        CMD_PRE: begin
          if (sel_busy) rsn = RSN_AP_BUSY;
          else          pre_sel = hit;
        end
        CMD_PALL: pall = 1'b1;
        CMD_REF: begin
          if (any_open) rsn = RSN_NOT_IDLE;
        end
        CMD_MRS: begin
          if (any_open)                      rsn = RSN_NOT_IDLE;
          else if (mode_bl inside {[3'd4:3'd6]}) rsn = RSN_BAD_MODE;
          else                               mrs_load = 1'b1;
        end
        default: ;
      endcase
    end
    illegal = (rsn != RSN_NONE);
    reason  = rsn;
  end

endmodule

// File: rtl/sbt_bank_slot.sv
module sbt_bank_slot #(
  parameter int ROW_W = 12,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_req,
  input  logic             close_req,
  input  logic             ap_start,
  input  logic [CNT_W-1:0] ap_len,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row,
  output logic             ap_busy
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             open_q, open_d;
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ROW_W-1:0] row_q;
  logic             row_en;

  always_comb begin
    open_d = open_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    row_en = 1'b0;
    if (close_req) begin
      open_d = 1'b0;
      busy_d = 1'b0;
    end else if (open_req) begin
      open_d = 1'b1;
      row_en = 1'b1;
    end else if (ap_start) begin
      if (ap_len <= ONE) begin
        open_d = 1'b0;
      end else begin
        busy_d = 1'b1;
        cnt_d  = ap_len - ONE;
      end
    end else if (busy_q) begin
      if (cnt_q == ONE) begin
        open_d = 1'b0;
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      open_q <= open_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (row_en) row_q <= row_in;
  end

  assign is_open = open_q;
  assign row     = row_q;
  assign ap_busy = busy_q;

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int BANK_W    = 2,
  parameter int MAX_BURST = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [3:0]                   cmd_code,
  input  logic [BANK_W-1:0]            cmd_bank,
  input  logic [ROW_W-1:0]             cmd_addr,
  output logic [(1<<BANK_W)-1:0]       bank_open_o,
  output logic [(1<<BANK_W)*ROW_W-1:0] bank_row_o,
  output logic                         configured_o,
  output logic                         illegal_o,
  output logic [2:0]                   illegal_reason_o
);
  localparam int NB    = 1 << BANK_W;
  localparam int CNT_W = $clog2(MAX_BURST + 1);

  logic [NB-1:0]    act_sel, pre_sel, wra_sel, busy_vec, open_vec;
  logic             pall, mrs_load, wra_ban, cfg;
  logic [CNT_W-1:0] wr_len;
  logic             ill_d, ill_q;
  sbt_reason_e      rsn_d;
  logic [2:0]       rsn_q;

  sbt_mode_reg #(.CNT_W(CNT_W)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (mrs_load),
    .bl_in      (cmd_addr[2:0]),
    .single_in  (cmd_addr[9]),
    .configured (cfg),
    .wra_ban    (wra_ban),
    .wr_len     (wr_len)
  );

  sbt_cmd_check #(.NB(NB), .BANK_W(BANK_W)) u_check (
    .cmd        (sbt_cmd_e'(cmd_code)),
    .bank       (cmd_bank),
    .configured (cfg),
    .open       (open_vec),
    .busy       (busy_vec),
    .wra_ban    (wra_ban),
    .mode_bl    (cmd_addr[2:0]),
    .illegal    (ill_d),
    .reason     (rsn_d),
    .act_sel    (act_sel),
    .pre_sel    (pre_sel),
    .wra_sel    (wra_sel),
    .pall       (pall),
    .mrs_load   (mrs_load)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sbt_bank_slot #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_req  (act_sel[b]),
      .close_req (pre_sel[b] | pall),
      .ap_start  (wra_sel[b]),
      .ap_len    (wr_len),
      .row_in    (cmd_addr),
      .is_open   (open_vec[b]),
      .row       (bank_row_o[b*ROW_W +: ROW_W]),
      .ap_busy   (busy_vec[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ill_q <= 1'b0;
      rsn_q <= 3'd0;
    end else begin
      ill_q <= ill_d;
      rsn_q <= rsn_d;
    end
  end

  assign bank_open_o      = open_vec;
  assign configured_o     = cfg;
  assign illegal_o        = ill_q;
  assign illegal_reason_o = rsn_q;

endmodule

// File: rtl/sbt_checker.sv
module sbt_checker
  import sbt_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [3:0]                   cmd_code,
  input logic [BANK_W-1:0]            cmd_bank,
  input logic [ROW_W-1:0]             cmd_addr,
  input logic [(1<<BANK_W)-1:0]       bank_open_o,
  input logic [(1<<BANK_W)*ROW_W-1:0] bank_row_o,
  input logic                         configured_o,
  input logic                         illegal_o,
  input logic [2:0]                   illegal_reason_o,
  input logic                         wra_ban
);
  logic [BANK_W-1:0] prev_bank;
  logic [ROW_W-1:0]  prev_addr;

  always_ff @(posedge clk) begin
    prev_bank <= cmd_bank;
    prev_addr <= cmd_addr;
  end

  logic [ROW_W-1:0] prev_row;
  assign prev_row = bank_row_o[prev_bank*ROW_W +: ROW_W];

  logic acc_cmd;
  assign acc_cmd = (cmd_code == CMD_RD) || (cmd_code == CMD_WR) ||
                   ((cmd_code == CMD_WRA) && !wra_ban);

  p_idle_unconfigured_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !configured_o |-> (bank_open_o == '0));

  p_reject_unconfigured_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!configured_o && (cmd_code >= 4'd1) && (cmd_code <= 4'd7))
      |=> (illegal_o && illegal_reason_o == RSN_UNCFG));

  p_activate_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (configured_o && cmd_code == CMD_ACT && !bank_open_o[cmd_bank])
      |=> (bank_open_o[prev_bank] && prev_row == prev_addr && !illegal_o));

  p_double_activate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (configured_o && cmd_code == CMD_ACT && bank_open_o[cmd_bank])
      |=> (illegal_o && $stable(bank_row_o)));

  p_access_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (configured_o && acc_cmd && !bank_open_o[cmd_bank])
      |=> (illegal_o && illegal_reason_o == RSN_IDLE_BANK));

  p_precharge_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (configured_o && cmd_code == CMD_PALL) |=> (bank_open_o == '0));

  p_fullpage_ap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (configured_o && cmd_code == CMD_WRA && wra_ban)
      |=> (illegal_o && illegal_reason_o == RSN_FULLPAGE_AP));

  p_refresh_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (configured_o && cmd_code == CMD_REF && (|bank_open_o))
      |=> (illegal_o && illegal_reason_o == RSN_NOT_IDLE));

  p_reason_pairs_r12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o == (illegal_reason_o != 3'd0));

endmodule

bind sdram_bank_tracker sbt_checker #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cmd_code         (cmd_code),
  .cmd_bank         (cmd_bank),
  .cmd_addr         (cmd_addr),
  .bank_open_o      (bank_open_o),
  .bank_row_o       (bank_row_o),
  .configured_o     (configured_o),
  .illegal_o        (illegal_o),
  .illegal_reason_o (illegal_reason_o),
  .wra_ban          (wra_ban)
);

// File: tb/sim_sdram_bank_tracker.sv
`timescale 1ns/1ps
module sim_sdram_bank_tracker;

  logic        clk;
  logic        rst_n;
  logic [3:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_addr;
  logic [3:0]  bank_open_o;
  logic [47:0] bank_row_o;
  logic        configured_o;
  logic        illegal_o;
  logic [2:0]  illegal_reason_o;

  sdram_bank_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .bank_open_o(bank_open_o), .bank_row_o(bank_row_o),
    .configured_o(configured_o), .illegal_o(illegal_o),
    .illegal_reason_o(illegal_reason_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  bit          m_cfg;
  bit [2:0]    m_bl;
  bit          m_single;
  bit [3:0]    m_open, m_busy, m_rowv;
  int          m_cnt [4];
  logic [11:0] m_row [4];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] c, input int rs);
    if (rs == 1) return "R2";
    if (rs == 6) return "R10";
    if (rs == 4) return "R9";
    case (c)
      4'd1: return "R5";
      4'd2, 4'd3: return "R6";
      4'd4: return "R8";
      4'd5, 4'd6: return "R7";
      4'd7: return "R11";
      4'd8: return "R3";
      default: return "R8";
    endcase
  endfunction

  // one command cycle: called at a falling edge, returns at the next one
  task automatic step(input logic [3:0] c, input logic [1:0] b, input logic [11:0] a);
    int  rs;
    bit  act, wra, pre, pall, mrs, ban;
    int  len;
    string tag;
    cmd_code = c; cmd_bank = b; cmd_addr = a;
    rs = 0; act = 0; wra = 0; pre = 0; pall = 0; mrs = 0;
    ban = !m_single && (m_bl == 3'd7);
    len = m_single ? 1 : (1 << m_bl[1:0]);
    if (c >= 4'd1 && c <= 4'd7 && !m_cfg) rs = 1;
    else begin
      case (c)
        4'd1: if (m_busy[b]) rs = 6; else if (m_open[b]) rs = 3; else act = 1;
        4'd2, 4'd3: if (m_busy[b]) rs = 6; else if (!m_open[b]) rs = 2;
        4'd4: if (ban) rs = 4; else if (m_busy[b]) rs = 6;
              else if (!m_open[b]) rs = 2; else wra = 1;
        4'd5: if (m_busy[b]) rs = 6; else pre = 1;
        4'd6: pall = 1;
        4'd7: if (|m_open) rs = 5;
        4'd8: if (|m_open) rs = 5; else if (a[2:0] >= 3'd4 && a[2:0] <= 3'd6) rs = 7;
              else mrs = 1;
        default: ;
      endcase
    end
    for (int k = 0; k < 4; k++) begin
      if (pall || (pre && b == k)) begin
        m_open[k] = 0; m_busy[k] = 0;
      end else if (act && b == k) begin
        m_open[k] = 1; m_row[k] = a; m_rowv[k] = 1;
      end else if (wra && b == k) begin
        if (len == 1) m_open[k] = 0;
        else begin m_busy[k] = 1; m_cnt[k] = len - 1; end
      end else if (m_busy[k]) begin
        if (m_cnt[k] == 1) begin m_open[k] = 0; m_busy[k] = 0; end
        else m_cnt[k]--;
      end
    end
    if (mrs) begin m_cfg = 1; m_bl = a[2:0]; m_single = a[9]; end
    tag = tag_of(c, rs);
    @(negedge clk);
    // R12: verdict and reason of the previous command
    check({illegal_o, illegal_reason_o} == {rs != 0, 3'(rs)}, tag, "illegal/reason",
          {illegal_o, illegal_reason_o}, {rs != 0, 3'(rs)});
    check(bank_open_o == m_open, tag, "open flags", bank_open_o, m_open);
    check(configured_o == m_cfg, "R3", "configured", configured_o, m_cfg);
    for (int k = 0; k < 4; k++)
      if (m_rowv[k])
        check(bank_row_o[k*12 +: 12] == m_row[k], "R4", "row",
              bank_row_o[k*12 +: 12], m_row[k]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(4'd0, 2'd0, 12'd0);
  endtask

  function automatic logic [11:0] mode_word(input logic [2:0] bl, input bit single);
    logic [11:0] w;
    w = 12'd0;
    w[2:0] = bl;
    w[9] = single;
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] bl_pick [6];
    void'($urandom(32'd20240611));
    bl_pick[0] = 3'd0; bl_pick[1] = 3'd1; bl_pick[2] = 3'd2;
    bl_pick[3] = 3'd3; bl_pick[4] = 3'd7; bl_pick[5] = 3'd5;
    m_cfg = 0; m_bl = 0; m_single = 0; m_open = 0; m_busy = 0; m_rowv = 0;
    for (int k = 0; k < 4; k++) begin m_cnt[k] = 0; m_row[k] = '0; end
    cmd_code = 4'd0; cmd_bank = 2'd0; cmd_addr = 12'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check(bank_open_o == 4'd0 && !configured_o && !illegal_o, "R1", "reset state",
          {bank_open_o, configured_o, illegal_o}, 6'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bank_open_o == 4'd0 && !configured_o && !illegal_o, "R1", "after reset",
          {bank_open_o, configured_o, illegal_o}, 6'd0);

    // R2: everything blocked before mode set
    step(4'd1, 2'd1, 12'h555);
    step(4'd2, 2'd0, 12'h000);
    step(4'd7, 2'd0, 12'h000);
    step(4'd12, 2'd0, 12'h000);           // unused code acts as NOP
    // R3: reserved burst code, then a valid burst of 4
    step(4'd8, 2'd0, mode_word(3'd5, 0));
    step(4'd8, 2'd0, mode_word(3'd2, 0));
    // R4/R5: bank decode and row latch
    step(4'd1, 2'd1, 12'hABC);
    step(4'd1, 2'd2, 12'h123);
    step(4'd1, 2'd1, 12'h777);            // R5 reject, row kept
    step(4'd2, 2'd0, 12'h000);            // R6 closed bank
    step(4'd7, 2'd0, 12'h000);            // R11 refresh with open banks
    // R8/R10: burst-of-4 auto-precharge on bank 1
    step(4'd4, 2'd1, 12'h010);
    step(4'd2, 2'd1, 12'h000);            // R10 busy
    step(4'd5, 2'd1, 12'h000);            // R10 busy
    idle(3);
    step(4'd8, 2'd0, mode_word(3'd1, 0)); // R11 mode set with bank open
    step(4'd5, 2'd2, 12'h000);            // R7 close bank 2
    step(4'd5, 2'd0, 12'h000);            // R7 idle bank, legal
    step(4'd7, 2'd0, 12'h000);            // R11 legal refresh
    // R9: full page, burst mode
    step(4'd8, 2'd0, mode_word(3'd7, 0));
    step(4'd1, 2'd3, 12'hFED);
    step(4'd4, 2'd3, 12'h000);
    step(4'd6, 2'd0, 12'h000);
    // R9: full page, single-write mode
    step(4'd8, 2'd0, mode_word(3'd7, 1));
    step(4'd1, 2'd3, 12'h0F0);
    step(4'd4, 2'd3, 12'h000);
    idle(1);
    // R8: burst of 8 and R7 cancel by precharge all
    step(4'd8, 2'd0, mode_word(3'd3, 0));
    step(4'd1, 2'd0, 12'h101);
    step(4'd1, 2'd3, 12'h303);
    step(4'd4, 2'd0, 12'h000);
    idle(3);
    step(4'd6, 2'd0, 12'h000);
    idle(8);

    for (int i = 0; i < 1500; i++) begin
      int r;
      logic [3:0] c;
      logic [11:0] a;
      r = $urandom % 20;
      case (r)
        0, 1, 17, 18, 19: c = 4'd0;
        2, 3, 4, 5:       c = 4'd1;
        6, 7:             c = 4'd2;
        8, 9:             c = 4'd3;
        10, 11:           c = 4'd4;
        12, 13:           c = 4'd5;
        14:               c = 4'd6;
        15:               c = 4'd7;
        default:          c = 4'd8;
      endcase
      a = 12'($urandom);
      if (c == 4'd8) a = mode_word(bl_pick[$urandom % 6], bit'($urandom % 2));
      step(c, 2'($urandom), a);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule